// File: doc/BRIEF.md
# Device Reset Sequencer with Lock Verification

This block brings an external device out of reset in a timed sequence, then decides whether the device came up cleanly. A one-cycle start pulse drives the active-low device reset output low. The output stays low for a fixed hold time. It then stays low until the board's clocks are reported stable, and for a further fixed time after that. Once the output is released, the sequencer waits for two more intervals before it samples the device status. The first interval lets the device's internal start-up timer run out and its clock synthesizer settle. The second lets its serial link settle.

The status check passes only when all of the following hold:
- the device reports that its start-up timer has expired;
- every monitored PLL out-of-lock flag is clear;
- the serial-link PLL reports that it has settled.

A failed check starts the whole sequence again from the reset-low step. This also happens when the wait for stable clocks runs out. The sequencer makes a bounded number of attempts and reports failure after the last one. Every interval is a parameter counted in clock cycles, so the same block serves any clock rate. The defaults assume 100 MHz and include about 1 ms of margin on the 1 ms and 14 ms waits.

Top module: `devrst_sequencer`

## Requirements
- R1: After reset, `dev_rst_n_o` is 1 and `busy_o`, `done_o`, `pass_o` and `fail_o` are all 0.
- R2: When `start_i` is sampled high while idle, `busy_o` is 1 and `dev_rst_n_o` is 0 in the next cycle. `pass_o` and `fail_o` are cleared in that same cycle.
- R3: In each attempt, `dev_rst_n_o` stays low for the hold interval (`HOLD_CYC` cycles). It then stays low for the cycles spent waiting for `clk_stable_i`, which is at least one cycle and includes the cycle in which `clk_stable_i` is seen high. After that it stays low for `POST_CYC` more cycles. Any value of `clk_stable_i` during the hold interval has no effect.
- R4: After release, the sequencer waits `SETTLE_CYC + IFACE_CYC` cycles and then evaluates status for one cycle. On a pass, `done_o` rises in the cycle after that evaluation, which is `SETTLE_CYC + IFACE_CYC + 2` cycles after the first high cycle of `dev_rst_n_o`, counting that first cycle as 1.
- R5: An attempt passes only if all of the following hold during the evaluation cycle:
  - `tmr_expired_i` = 1;
  - `iface_settled_i` = 1;
  - `pll_oolock_i[i]` = 0 for every bit `i` where `LOCK_MASK[i]` = 1.

  Flag bits whose mask bit is 0 are ignored.
- R6: When an attempt fails and fewer than `MAX_TRIES` attempts have been made, `dev_rst_n_o` goes low again in the next cycle and a new attempt starts. After `MAX_TRIES` failed attempts, the sequencer ends with `fail_o` = 1.
- R7: If `clk_stable_i` stays low for `STABLE_TMO_CYC` cycles of the clock wait, the attempt fails. The reset output stays low into the next attempt, so `MAX_TRIES` timeouts in a row give one low interval of `MAX_TRIES*(HOLD_CYC+STABLE_TMO_CYC)` cycles. `done_o` then comes with `fail_o` = 1 in the first cycle in which the reset output is high again.
- R8: `done_o` is high for exactly one cycle per run, and in that cycle exactly one of `pass_o` and `fail_o` is 1. The verdict holds until the next accepted start.
- R9: A `start_i` pulse while `busy_o` = 1 is ignored. The timing of the sequence in progress is unchanged and only one `done_o` pulse occurs.
- R10: `dev_rst_n_o` is never low while `busy_o` = 0, and `pass_o` and `fail_o` are never both 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| start_i | input | 1 | Start pulse; ignored while busy |
| clk_stable_i | input | 1 | External clocks and reference select are stable |
| tmr_expired_i | input | 1 | Device's internal start-up timer has expired |
| pll_oolock_i | input | NUM_LOCK | PLL out-of-lock flags, one per bit |
| iface_settled_i | input | 1 | Serial-link PLL has settled |
| dev_rst_n_o | output | 1 | Active-low reset output to the device |
| busy_o | output | 1 | A sequence is in progress |
| done_o | output | 1 | One-cycle pulse at the end of a run |
| pass_o | output | 1 | Verdict: the device came up cleanly |
| fail_o | output | 1 | Verdict: all attempts failed |

## Verification
Every result is tied to a fixed cycle count from a known event:
- Busy and the reset-low output appear one cycle after an accepted start.
- Each low interval lasts the hold time, plus the cycles spent waiting for stable clocks including the cycle in which stability is seen, plus the post-stable time.
- The gap between a release and the next reset-low lasts the settle time, plus the link time, plus one evaluation cycle.
- On a pass, the done pulse appears one cycle after that evaluation cycle.

The bench samples at the falling edge of the clock. It measures the length of every low and high interval by counting the cycles as they happen, and it compares each length with the value it computes from the parameters. It drives the stable-clock input from its count of low cycles, so a stability delay of j cycles moves the release by exactly j cycles. After each done pulse it checks that the pulse has gone in the very next cycle and that the verdict has not changed.

// File: rtl/devrst_pkg.sv
// Package: shared state encoding for the device reset sequencer.
// Assumes: nothing beyond IEEE 1800-2017 enums.
package devrst_pkg;

    typedef enum logic [2:0] {
        ST_IDLE   = 3'd0,
        ST_HOLD   = 3'd1,
        ST_WAITCK = 3'd2,
        ST_POST   = 3'd3,
        ST_SETTLE = 3'd4,
        ST_IFACE  = 3'd5,
        ST_EVAL   = 3'd6
    } seq_state_t;

    // Larger of two interval lengths, used to size the shared timer.
    function automatic int imax(input int a, input int b);
        return (a > b) ? a : b;
    endfunction

endpackage

// File: rtl/seq_timer.sv
// seq_timer: counts the cycles spent in the current sequencer state.
// Assumes: clr is asserted on the cycle before a new state begins, so the
// count is 0 in the first cycle of every state. The count saturates.
module seq_timer #(
    parameter int CW = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          clr,
    output logic [CW-1:0] cnt
);

    // Restart on clr, otherwise count up and stop at the top value.
    always_ff @(posedge clk) begin
        if (!rst_n)                 cnt <= '0;
        else if (clr)               cnt <= '0;
        else if (cnt != {CW{1'b1}}) cnt <= cnt + 1'b1;
    end

endmodule

// File: rtl/attempt_ctr.sv
// attempt_ctr: counts failed attempts within one run and flags the last one.
// Assumes: clr comes with each accepted start; inc comes with each retry.
module attempt_ctr #(
    parameter int MAX_TRIES = 3
) (
    input  logic clk,
    input  logic rst_n,
    input  logic clr,
    input  logic inc,
    output logic last
);

    localparam int AW = $clog2(MAX_TRIES + 1);

    logic [AW-1:0] tries_q;

    // Attempts already used up in this run.
    always_ff @(posedge clk) begin
        if (!rst_n)   tries_q <= '0;
        else if (clr) tries_q <= '0;
        else if (inc) tries_q <= tries_q + 1'b1;
    end

    // The attempt in progress is the final one allowed.
    assign last = (tries_q == AW'(MAX_TRIES - 1));

endmodule

// File: rtl/status_judge.sv
// status_judge: combines the device status flags into one pass decision.
// Assumes: flags are stable during the evaluation cycle. Only the
// out-of-lock bits selected by LOCK_MASK take part in the decision.
module status_judge #(
    parameter int                    NUM_LOCK  = 4,
    parameter logic [NUM_LOCK-1:0]   LOCK_MASK = '1
) (
    input  logic                tmr_expired,
    input  logic [NUM_LOCK-1:0] oolock,
    input  logic                iface_ok,
    output logic                healthy
);

    logic [NUM_LOCK-1:0] lock_bad;

    // One qualifier per flag: unmonitored bits are forced clear.
    for (genvar g = 0; g < NUM_LOCK; g++) begin : g_mask
        if (LOCK_MASK[g]) begin : g_on
            assign lock_bad[g] = oolock[g];
        end else begin : g_off
            assign lock_bad[g] = 1'b0;
        end
    end

    // Pass needs timer expired, link settled and every monitored lock flag clear.
    assign healthy = tmr_expired && iface_ok && !(|lock_bad);

endmodule

// File: rtl/devrst_sequencer.sv
// devrst_sequencer: drives an active-low device reset through hold,
// clock-stable wait, post-stable hold, release, settle and link waits,
// then judges device status. A failed attempt is retried from the start
// of the sequence, up to MAX_TRIES attempts in total.
// Assumes: all inputs are synchronous to clk; every *_CYC parameter and
// STABLE_TMO_CYC is at least 1.
module devrst_sequencer
    import devrst_pkg::*;
#(
    parameter int                  HOLD_CYC       = 200000,
    parameter int                  STABLE_TMO_CYC = 1000000,
    parameter int                  POST_CYC       = 100000,
    parameter int                  SETTLE_CYC     = 1500000,
    parameter int                  IFACE_CYC      = 20000,
    parameter int                  MAX_TRIES      = 3,
    parameter int                  NUM_LOCK       = 4,
    parameter logic [NUM_LOCK-1:0] LOCK_MASK      = 4'b1011
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                start_i,
    input  logic                clk_stable_i,
    input  logic                tmr_expired_i,
    input  logic [NUM_LOCK-1:0] pll_oolock_i,
    input  logic                iface_settled_i,
    output logic                dev_rst_n_o,
    output logic                busy_o,
    output logic                done_o,
    output logic                pass_o,
    output logic                fail_o
);

    localparam int LIM_MAX = imax(imax(HOLD_CYC, STABLE_TMO_CYC),
                                  imax(imax(POST_CYC, SETTLE_CYC), IFACE_CYC));
    localparam int CW = $clog2(LIM_MAX + 1);

    localparam logic [CW-1:0] HOLD_END   = CW'(HOLD_CYC - 1);
    localparam logic [CW-1:0] TMO_END    = CW'(STABLE_TMO_CYC - 1);
    localparam logic [CW-1:0] POST_END   = CW'(POST_CYC - 1);
    localparam logic [CW-1:0] SETTLE_END = CW'(SETTLE_CYC - 1);
    localparam logic [CW-1:0] IFACE_END  = CW'(IFACE_CYC - 1);

    seq_state_t    state_q, state_d;
    logic [CW-1:0] tcnt;
    logic          tclr;
    logic          last_try;
    logic          healthy;
    logic          accept;
    logic          attempt_bad;
    logic          fin_pass;
    logic          fin_fail;
    logic          retry;
    logic          done_q, pass_q, fail_q;

    seq_timer #(.CW(CW)) timer_i (
        .clk   (clk),
        .rst_n (rst_n),
        .clr   (tclr),
        .cnt   (tcnt)
    );

    attempt_ctr #(.MAX_TRIES(MAX_TRIES)) tries_i (
        .clk   (clk),
        .rst_n (rst_n),
        .clr   (accept),
        .inc   (retry),
        .last  (last_try)
    );

    status_judge #(.NUM_LOCK(NUM_LOCK), .LOCK_MASK(LOCK_MASK)) judge_i (
        .tmr_expired (tmr_expired_i),
        .oolock      (pll_oolock_i),
        .iface_ok    (iface_settled_i),
        .healthy     (healthy)
    );

    // Next-state logic and the end-of-attempt events.
    always_comb begin
        state_d     = state_q;
        accept      = 1'b0;
        attempt_bad = 1'b0;
        fin_pass    = 1'b0;
        unique case (state_q)
            ST_IDLE: begin
                if (start_i) begin
                    accept  = 1'b1;
                    state_d = ST_HOLD;
                end
            end
            ST_HOLD:   if (tcnt == HOLD_END) state_d = ST_WAITCK;
            ST_WAITCK: begin
                if (clk_stable_i)        state_d = ST_POST;
                else if (tcnt == TMO_END) attempt_bad = 1'b1;
            end
            ST_POST:   if (tcnt == POST_END)   state_d = ST_SETTLE;
            ST_SETTLE: if (tcnt == SETTLE_END) state_d = ST_IFACE;
            ST_IFACE:  if (tcnt == IFACE_END)  state_d = ST_EVAL;
            ST_EVAL: begin
                if (healthy) begin
                    fin_pass = 1'b1;
                    state_d  = ST_IDLE;
                end else begin
                    attempt_bad = 1'b1;
                end
            end
            default:   state_d = ST_IDLE;
        endcase
        fin_fail = attempt_bad && last_try;
        retry    = attempt_bad && !last_try;
        if (fin_fail) state_d = ST_IDLE;
        if (retry)    state_d = ST_HOLD;
    end

    // Restart the interval timer whenever a new state (or a new attempt) begins.
    assign tclr = (state_d != state_q) || retry || (state_q == ST_IDLE);

    // State register.
    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    // Done pulse and held verdict, cleared by the next accepted start.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            done_q <= 1'b0;
            pass_q <= 1'b0;
            fail_q <= 1'b0;
        end else begin
            done_q <= fin_pass || fin_fail;
            if (accept) begin
                pass_q <= 1'b0;
                fail_q <= 1'b0;
            end else if (fin_pass) begin
                pass_q <= 1'b1;
            end else if (fin_fail) begin
                fail_q <= 1'b1;
            end
        end
    end

    // Reset output is low through hold, clock wait and post-stable hold.
    assign dev_rst_n_o = !(state_q inside {ST_HOLD, ST_WAITCK, ST_POST});
    assign busy_o      = (state_q != ST_IDLE);
    assign done_o      = done_q;
    assign pass_o      = pass_q;
    assign fail_o      = fail_q;

endmodule

// File: rtl/devrst_sequencer_chk.sv
// devrst_sequencer_chk: temporal checks on the sequencer's ports, attached
// by bind. Interval lengths are measured with counters so that no long
// $past window is needed.
module devrst_sequencer_chk #(
    parameter int HOLD_CYC   = 4,
    parameter int POST_CYC   = 3,
    parameter int SETTLE_CYC = 5,
    parameter int IFACE_CYC  = 2
) (
    input logic clk,
    input logic rst_n,
    input logic start_i,
    input logic dev_rst_n_o,
    input logic busy_o,
    input logic done_o,
    input logic pass_o,
    input logic fail_o
);

    logic [31:0] low_run;
    logic [31:0] high_run;

    // Length of the current or just-ended low and high runs of the reset output.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            low_run  <= '0;
            high_run <= '0;
        end else begin
            low_run  <= dev_rst_n_o ? 32'd0 : low_run + 32'd1;
            high_run <= dev_rst_n_o ? high_run + 32'd1 : 32'd0;
        end
    end

    // R2
    start_accept_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!busy_o && start_i) |=> (busy_o && !dev_rst_n_o && !pass_o && !fail_o));

    // R3
    low_min_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(dev_rst_n_o) |-> (low_run >= 32'(HOLD_CYC + POST_CYC + 1)));

    // R4
    release_to_done_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (done_o && pass_o) |-> (high_run == 32'(SETTLE_CYC + IFACE_CYC + 1)));

    // R8
    done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |=> !done_o);

    // R8
    done_verdict_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |-> ((pass_o != fail_o) && !busy_o));

    // R8
    verdict_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!busy_o && !done_o) |-> ($stable(pass_o) && $stable(fail_o)));

    // R10
    pin_idle_high_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !busy_o |-> dev_rst_n_o);

    // R10
    verdict_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(pass_o && fail_o));

endmodule

bind devrst_sequencer devrst_sequencer_chk #(
    .HOLD_CYC   (HOLD_CYC),
    .POST_CYC   (POST_CYC),
    .SETTLE_CYC (SETTLE_CYC),
    .IFACE_CYC  (IFACE_CYC)
) chk_i (
    .clk         (clk),
    .rst_n       (rst_n),
    .start_i     (start_i),
    .dev_rst_n_o (dev_rst_n_o),
    .busy_o      (busy_o),
    .done_o      (done_o),
    .pass_o      (pass_o),
    .fail_o      (fail_o)
);

// File: tb/devrst_sequencer_tb.sv
// Bench for devrst_sequencer: sweeps status patterns, clock-stable delays,
// retries, timeouts and starts issued while busy, on a small configuration.
module devrst_sequencer_tb_top;

    localparam int CLK_PERIOD = 10;
    localparam int H    = 4;
    localparam int T    = 6;
    localparam int P    = 3;
    localparam int S    = 5;
    localparam int I    = 2;
    localparam int MAXT = 3;
    localparam int NL   = 4;
    localparam logic [NL-1:0] MASK = 4'b1011;
    localparam int NEVER = 1000;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          start_i = 1'b0;
    logic          clk_stable_i = 1'b0;
    logic          tmr_expired_i = 1'b0;
    logic [NL-1:0] pll_oolock_i = '0;
    logic          iface_settled_i = 1'b0;
    logic          dev_rst_n_o, busy_o, done_o, pass_o, fail_o;

    int checks = 0;
    int failures = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    devrst_sequencer #(
        .HOLD_CYC(H), .STABLE_TMO_CYC(T), .POST_CYC(P), .SETTLE_CYC(S),
        .IFACE_CYC(I), .MAX_TRIES(MAXT), .NUM_LOCK(NL), .LOCK_MASK(MASK)
    ) dut_i (
        .clk(clk), .rst_n(rst_n), .start_i(start_i), .clk_stable_i(clk_stable_i),
        .tmr_expired_i(tmr_expired_i), .pll_oolock_i(pll_oolock_i),
        .iface_settled_i(iface_settled_i), .dev_rst_n_o(dev_rst_n_o),
        .busy_o(busy_o), .done_o(done_o), .pass_o(pass_o), .fail_o(fail_o)
    );

    task automatic check(input bit cond, input string req, input int act, input int exp);
        checks++;
        if (!cond) begin
            failures++;
            $display("FAIL %s actual=%0d expected=%0d at %0t", req, act, exp, $time);
        end
    endtask

    // Status word: [5]=link settled, [4]=timer expired, [3:0]=out-of-lock flags.
    function automatic bit status_ok(input logic [5:0] st);
        return st[5] && st[4] && ((st[3:0] & MASK) == '0);
    endfunction

    task automatic apply_status(input logic [5:0] st);
        iface_settled_i = st[5];
        tmr_expired_i   = st[4];
        pll_oolock_i    = st[3:0];
    endtask

    // One run: status st_a before attempt sw, st_b from attempt sw on;
    // clk_stable seen in wait cycle jd (>= T means never); poke issues starts while busy.
    task automatic run_case(input logic [5:0] st_a, input logic [5:0] st_b, input int sw,
                            input int jd, input bit poke, input string req);
        bit exp_pass = 0;
        int exp_att = MAXT;
        bit tmo = (jd >= T);
        int lowc = 1, highc = 0, segs = 1, cyc = 1;
        bit prev_low = 1;
        bit got_done = 0;
        if (!tmo) begin
            for (int a = 1; a <= MAXT; a++) begin
                if (!exp_pass && status_ok((a >= sw) ? st_b : st_a)) begin
                    exp_pass = 1;
                    exp_att  = a;
                end
            end
        end
        @(negedge clk);
        start_i = 1'b1;
        clk_stable_i = 1'b0;
        apply_status((1 >= sw) ? st_b : st_a);
        @(negedge clk);
        start_i = 1'b0;
        check(busy_o && !dev_rst_n_o, "R2 start->busy,low", {busy_o, dev_rst_n_o}, 2);
        check(!pass_o && !fail_o, "R8 verdict cleared by start", {pass_o, fail_o}, 0);
        while (!got_done && cyc < 3000) begin
            clk_stable_i = !dev_rst_n_o && (lowc >= H + 1 + jd);
            apply_status((segs >= sw) ? st_b : st_a);
            start_i = poke && (cyc == 2 || highc == 2);
            @(negedge clk);
            cyc++;
            if (!dev_rst_n_o) begin
                if (!prev_low) begin
                    check(highc == S + I + 1, "R4 release-to-retry gap", highc, S + I + 1);
                    segs++;
                    lowc = 1;
                end else begin
                    lowc++;
                end
                prev_low = 1;
            end else begin
                if (prev_low) begin
                    if (tmo)
                        check(lowc == MAXT * (H + T), "R7 timeout low length", lowc, MAXT * (H + T));
                    else
                        check(lowc == H + 1 + jd + P, "R3 low length", lowc, H + 1 + jd + P);
                    highc = 1;
                end else begin
                    highc++;
                end
                prev_low = 0;
            end
            got_done = done_o;
        end
        start_i = 1'b0;
        clk_stable_i = 1'b0;
        check(got_done, req, got_done, 1);
        if (tmo) begin
            check(highc == 1, "R7 done with release", highc, 1);
            check(segs == 1, "R7 one continuous low", segs, 1);
        end else begin
            check(!exp_pass || highc == S + I + 2, "R4 release-to-done", highc, S + I + 2);
            check(segs == exp_att, "R6 attempts used", segs, exp_att);
        end
        check(pass_o == exp_pass && fail_o == !exp_pass, req, {pass_o, fail_o}, {exp_pass, !exp_pass});
        @(negedge clk);
        check(!done_o && !busy_o && dev_rst_n_o, "R8 done one cycle, R10 idle pin high",
              {done_o, busy_o, dev_rst_n_o}, 1);
        repeat (3) @(negedge clk);
        check(pass_o == exp_pass && fail_o == !exp_pass, "R8 verdict held", {pass_o, fail_o},
              {exp_pass, !exp_pass});
    endtask

    // Watchdog: a hung run counts as a failure and still reports.
    initial begin
        repeat (150000) @(posedge clk);
        failures++;
        $display("FAIL watchdog actual=running expected=finished");
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1 reset state
        check(dev_rst_n_o && !busy_o && !done_o && !pass_o && !fail_o, "R1 reset state",
              {dev_rst_n_o, busy_o, done_o, pass_o, fail_o}, 16);

        // R5: every combination of the six status bits, single attempt window.
        for (int v = 0; v < 64; v++) begin
            run_case(6'(v), 6'(v), 1, 0, 1'b0, "R5 status sweep");
        end

        // R3: clock-stable seen at every wait cycle inside the timeout.
        for (int j = 0; j < T; j++) begin
            run_case(6'b110000, 6'b110000, 1, j, 1'b0, "R3 stable delay sweep");
        end

        // R7: clocks never stable.
        run_case(6'b110000, 6'b110000, 1, NEVER, 1'b0, "R7 stable timeout");

        // R6: device comes good on the second and on the third attempt.
        run_case(6'b100001, 6'b110000, 2, 0, 1'b0, "R6 pass on retry 2");
        run_case(6'b010000, 6'b110100, 3, 1, 1'b0, "R6 pass on retry 3");
        run_case(6'b110010, 6'b110010, 1, 2, 1'b0, "R6 fail after all tries");

        // R9: extra starts while busy leave timing and verdict untouched.
        run_case(6'b110000, 6'b110000, 1, 1, 1'b1, "R9 start while busy, pass");
        run_case(6'b000000, 6'b000000, 1, 0, 1'b1, "R9 start while busy, fail");

        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

endmodule